// File: doc/BRIEF.md
# Clock Frequency and Loss Supervisor

This block checks the main (PLL-derived) clock against a reference clock that does not depend on it. The main domain counts its own edges. Every fixed window of reference-clock cycles, the reference domain asks for that count through a toggle handshake. The returned count is then compared with a low bound and a high bound that software sets.

The block reports two kinds of fault separately. A clock that has stopped is declared lost in one of two cases: no fresh count comes back before the next window closes, or the count is below a small floor. A clock that still runs but sits outside the bounds is reported as a suspected PLL fault.

Loss puts the block into failsafe. A glitch-free clock multiplexer, built with two-flop synchronizers, moves the downstream system clock over to a backup oscillator. That selection stays in place until software clears it. Range checking is suppressed for a programmable number of evaluated windows after reset or after a relock pulse, so start-up transients are not reported.

Top module: `clk_freq_supervisor`

## Requirements
- R1: `meas_count` holds the number of main-clock rising edges between two consecutive window boundaries. A window is WIN_CYC (default 32) reference cycles. The value lies within ±1 of WIN_CYC·T_ref/T_main and is refreshed once per window.
- R2: `meas_count` saturates at 2^CNT_W−1 (255 by default). A faster clock never wraps it.
- R3: Loss is declared in two cases: a window closes while the previous window's count has not yet come back, or a returned count is below LOSS_MIN (default 2). On loss, `loss_flag` is set and, for a missing count, `meas_count` reads 0.
- R4: A returned count that is at least LOSS_MIN and lies outside the inclusive range [`lo_bound`, `hi_bound`] sets `range_flag`. A missing count never sets `range_flag`.
- R5: `loss_flag` is sticky and `sel_backup` equals it. A `clear_fail` pulse clears both flags, and loss is set again if the main clock is still absent.
- R6: While `sel_backup` is 1, `sys_clk` carries the backup clock's edges. The main gate and the backup gate are never open at the same time.
- R7: While `sel_backup` is 0 and the main clock runs, `sys_clk` carries the main clock's edges, including after a return from failover.
- R8: After reset, and after a `relock` pulse, the first `blank_windows` evaluated windows never set `range_flag`. Later windows set it as in R4.
- R9: `irq` is 1 exactly when `loss_flag` or `range_flag` is 1.
- R10: After reset, `loss_flag`, `range_flag`, `sel_backup`, `irq` and `meas_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock; all control and status live here |
| main_clk | input | 1 | Supervised main clock |
| bkp_clk | input | 1 | Backup oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| lo_bound | input | CNT_W | Lowest acceptable edge count per window |
| hi_bound | input | CNT_W | Highest acceptable edge count per window |
| blank_windows | input | BLANK_W | Evaluated windows to ignore for range after reset or relock |
| relock | input | 1 | One-cycle pulse that restarts range blanking |
| clear_fail | input | 1 | One-cycle pulse that clears the loss and range flags |
| meas_count | output | CNT_W | Last evaluated edge count |
| loss_flag | output | 1 | Sticky main-clock loss indication |
| range_flag | output | 1 | Sticky off-frequency indication |
| irq | output | 1 | Interrupt level, OR of the two flags |
| sel_backup | output | 1 | Clock mux select, 1 = backup oscillator |
| sys_clk | output | 1 | Glitch-free muxed system clock |

## Verification
The hardest state to reach is a main clock that stops partway through a window. It leaves one short count, which may legitimately raise a range fault, followed by windows with no count at all. Those empty windows must raise only loss.

The bench reaches this state by gating its main-clock generator off at an arbitrary phase. It then clears both flags while the clock is still dead. Only the empty windows that follow are judged, so the distinction between loss and range is tested apart from the transient.

The same gate turned back on brings the system clock home from the backup, and edge counts on `sys_clk` confirm which source drives it.

// File: rtl/csup_pkg.sv
package csup_pkg;

  // A count below the floor means the main clock is effectively absent.
  function automatic logic count_below_floor(input int unsigned c, input int unsigned floor_v);
    return c < floor_v;
  endfunction

  // Inclusive band test used for the frequency check.
  function automatic logic count_in_band(input int unsigned c, input int unsigned lo,
                                         input int unsigned hi);
    return (c >= lo) && (c <= hi);
  endfunction

endpackage

// File: rtl/csup_main_count.sv
module csup_main_count #(
  parameter int CNT_W = 8
) (
  input  logic             main_clk,
  input  logic             rst_n,
  input  logic             req_t,
  output logic             ack_t,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       rq;
  logic [CNT_W-1:0] cnt;
  logic             req_edge;

  assign req_edge = rq[2] ^ rq[1];

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq    <= '0;
      cnt   <= '0;
      hold  <= '0;
      ack_t <= 1'b0;
    end else begin
      rq <= {rq[1:0], req_t};
      if (req_edge) begin
        hold  <= cnt;
        cnt   <= CNT_W'(1);
        ack_t <= ~ack_t;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_count_saturates_R2: assert property (@(posedge main_clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !req_edge) |=> (cnt == CNT_MAX));

  assert_hold_steady_R1: assert property (@(posedge main_clk) disable iff (!rst_n)
    !req_edge |=> $stable(hold));

endmodule

// File: rtl/csup_ref_eval.sv
module csup_ref_eval
  import csup_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WIN_CYC  = 32,
  parameter int LOSS_MIN = 2,
  parameter int BLANK_W  = 4
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   hold,
  input  logic               ack_t,
  input  logic [CNT_W-1:0]   lo_bound,
  input  logic [CNT_W-1:0]   hi_bound,
  input  logic [BLANK_W-1:0] blank_windows,
  input  logic               relock,
  input  logic               clear_fail,
  output logic               req_t,
  output logic [CNT_W-1:0]   meas_count,
  output logic               loss_flag,
  output logic               range_flag
);
  localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0]   win_cnt;
  logic [2:0]         ab;
  logic               pending;
  logic               armed;
  logic [BLANK_W-1:0] blank_left;

  // Named events for the assertions.
  logic win_end, ack_edge, ev_eval, ev_floor, ev_miss, ev_band, blanking;

  assign win_end  = (win_cnt == WIN_LAST);
  assign ack_edge = ab[2] ^ ab[1];
  assign ev_eval  = ack_edge;
  assign blanking = (blank_left != '0);
  assign ev_floor = ev_eval && count_below_floor(32'(hold), 32'(LOSS_MIN));
  assign ev_miss  = win_end && pending && !ack_edge;
  assign ev_band  = ev_eval && !ev_floor && !blanking &&
                    !count_in_band(32'(hold), 32'(lo_bound), 32'(hi_bound));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt    <= '0;
      req_t      <= 1'b0;
      ab         <= '0;
      pending    <= 1'b0;
      armed      <= 1'b0;
      blank_left <= '0;
      meas_count <= '0;
      loss_flag  <= 1'b0;
      range_flag <= 1'b0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      ab      <= {ab[1:0], ack_t};
      if (win_end) req_t <= ~req_t;

      if (win_end)       pending <= 1'b1;
      else if (ack_edge) pending <= 1'b0;

      if (ev_eval)      meas_count <= hold;
      else if (ev_miss) meas_count <= '0;

      if (!armed || relock) begin
        blank_left <= blank_windows;
        armed      <= 1'b1;
      end else if (ev_eval && !ev_floor && blanking) begin
        blank_left <= blank_left - 1'b1;
      end

      if (ev_floor || ev_miss) loss_flag <= 1'b1;
      else if (clear_fail)     loss_flag <= 1'b0;

      if (ev_band)         range_flag <= 1'b1;
      else if (clear_fail) range_flag <= 1'b0;
    end
  end

  assert_missing_count_loss_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ev_miss |=> loss_flag);

  assert_loss_sticky_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (loss_flag && !clear_fail) |=> loss_flag);

  assert_miss_not_range_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ev_miss && !range_flag) |=> !range_flag);

  assert_blanked_window_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ev_eval && blanking && !range_flag) |=> !range_flag);

endmodule

// File: rtl/csup_clk_mux.sv
module csup_clk_mux (
  input  logic main_clk,
  input  logic bkp_clk,
  input  logic rst_n,
  input  logic sel_backup,
  output logic sys_clk
);
  logic [1:0] ms, mb, bs, bm;
  logic       m_en, b_en;

  // Main side: select and backup gate state synchronised into the main domain.
  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= '0;
      mb <= '0;
    end else begin
      ms <= {ms[0], sel_backup};
      mb <= {mb[0], b_en};
    end
  end

  // A dead main clock cannot close its own gate, so failover closes it directly.
  always_ff @(negedge main_clk or negedge rst_n or posedge sel_backup) begin
    if (!rst_n)          m_en <= 1'b0;
    else if (sel_backup) m_en <= 1'b0;
    else                 m_en <= !ms[1] && !mb[1];
  end

  // Backup side: open only once the main gate is seen closed.
  always_ff @(posedge bkp_clk or negedge rst_n) begin
    if (!rst_n) begin
      bs <= '0;
      bm <= '0;
    end else begin
      bs <= {bs[0], sel_backup};
      bm <= {bm[0], m_en};
    end
  end

  always_ff @(negedge bkp_clk or negedge rst_n) begin
    if (!rst_n) b_en <= 1'b0;
    else        b_en <= bs[1] && !bm[1];
  end

  assign sys_clk = (main_clk & m_en) | (bkp_clk & b_en);

  assert_gates_exclusive_R6: assert property (@(posedge bkp_clk) disable iff (!rst_n)
    !(m_en && b_en));

endmodule

// File: rtl/clk_freq_supervisor.sv
module clk_freq_supervisor #(
  parameter int CNT_W    = 8,
  parameter int WIN_CYC  = 32,
  parameter int LOSS_MIN = 2,
  parameter int BLANK_W  = 4
) (
  input  logic               ref_clk,
  input  logic               main_clk,
  input  logic               bkp_clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   lo_bound,
  input  logic [CNT_W-1:0]   hi_bound,
  input  logic [BLANK_W-1:0] blank_windows,
  input  logic               relock,
  input  logic               clear_fail,
  output logic [CNT_W-1:0]   meas_count,
  output logic               loss_flag,
  output logic               range_flag,
  output logic               irq,
  output logic               sel_backup,
  output logic               sys_clk
);
  logic             req_w, ack_w;
  logic [CNT_W-1:0] hold_w;

  csup_main_count #(.CNT_W(CNT_W)) u_count (
    .main_clk(main_clk), .rst_n(rst_n), .req_t(req_w), .ack_t(ack_w), .hold(hold_w)
  );

  csup_ref_eval #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC), .LOSS_MIN(LOSS_MIN), .BLANK_W(BLANK_W)) u_eval (
    .ref_clk(ref_clk), .rst_n(rst_n), .hold(hold_w), .ack_t(ack_w),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .blank_windows(blank_windows),
    .relock(relock), .clear_fail(clear_fail), .req_t(req_w),
    .meas_count(meas_count), .loss_flag(loss_flag), .range_flag(range_flag)
  );

  assign sel_backup = loss_flag;
  assign irq        = loss_flag | range_flag;

  csup_clk_mux u_mux (
    .main_clk(main_clk), .bkp_clk(bkp_clk), .rst_n(rst_n),
    .sel_backup(sel_backup), .sys_clk(sys_clk)
  );

  assert_irq_level_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq == (loss_flag || range_flag));

endmodule

// File: tb/tb_clk_freq_supervisor.sv
`timescale 1ns/1ps
module tb_clk_freq_supervisor;
  localparam int WIN = 32;
  localparam int LO  = 48;
  localparam int HI  = 80;

  logic ref_clk = 0, main_clk = 0, bkp_clk = 0, rst_n = 0;
  logic [7:0] lo_bound = 8'(LO), hi_bound = 8'(HI);
  logic [3:0] blank_windows = 4'd2;
  logic relock = 0, clear_fail = 0;
  logic [7:0] meas_count;
  logic loss_flag, range_flag, irq, sel_backup, sys_clk;

  int checks = 0, fails = 0, sys_edges = 0;
  bit main_run = 1, done = 0;
  realtime main_half = 2.5;

  clk_freq_supervisor dut (
    .ref_clk(ref_clk), .main_clk(main_clk), .bkp_clk(bkp_clk), .rst_n(rst_n),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .blank_windows(blank_windows),
    .relock(relock), .clear_fail(clear_fail), .meas_count(meas_count),
    .loss_flag(loss_flag), .range_flag(range_flag), .irq(irq),
    .sel_backup(sel_backup), .sys_clk(sys_clk)
  );

  always #5 ref_clk = ~ref_clk;
  always #12.5 bkp_clk = ~bkp_clk;
  initial forever begin
    if (main_run) begin #(main_half) main_clk = ~main_clk; end
    else begin main_clk = 0; #1; end
  end
  always @(posedge sys_clk) sys_edges <= sys_edges + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_clear();
    clear_fail = 1; wref(1); clear_fail = 0;
  endtask

  function automatic int edges_in(input real span, input real period);
    return $rtoi(span / period);
  endfunction

  task automatic sys_rate(input string req, input real period);
    int e0, got, exp;
    e0 = sys_edges; #400; got = sys_edges - e0;
    exp = edges_in(400.0, period);
    chk(got >= exp - 1 && got <= exp + 1, req, got, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    wref(5);
    // R10: reset state
    chk(loss_flag == 0 && range_flag == 0 && sel_backup == 0 && irq == 0, "R10 flags", int'(irq), 0);
    chk(meas_count == 0, "R10 meas_count", int'(meas_count), 0);
    rst_n = 1;
    wref(3 * WIN);

    // R1 R2 R4 R9: frequency sweep
    for (int i = 0; i < 21; i++) begin
      real t, e, es;
      bit skip, exp_rng;
      t  = (i == 0) ? 1.0 : 2.0 + 0.5 * i;
      e  = (WIN * 10.0) / t;
      es = (e > 255.0) ? 255.0 : e;
      skip = ((e - LO) <= 2.0 && (LO - e) <= 2.0) || ((e - HI) <= 2.0 && (HI - e) <= 2.0);
      exp_rng = (es < LO) || (es > HI);
      main_half = t / 2.0;
      wref(3 * WIN);
      pulse_clear();
      wref(4 * WIN);
      chk(loss_flag == 0, "R3 no false loss", int'(loss_flag), 0);
      chk(real'(meas_count) >= es - 1.01 && real'(meas_count) <= es + 1.01,
          (e > 255.0) ? "R2 saturated count" : "R1 count", int'(meas_count), $rtoi(es));
      if (!skip) begin
        chk(range_flag == exp_rng, "R4 range", int'(range_flag), int'(exp_rng));
        chk(irq == exp_rng, "R9 irq", int'(irq), int'(exp_rng));
      end
    end

    // R8: blanking after relock with an off-frequency clock (count 32)
    main_half = 5.0;
    wref(2 * WIN);
    blank_windows = 4'd3;
    relock = 1; clear_fail = 1; wref(1); relock = 0; clear_fail = 0;
    wref(2 * WIN + 10);
    chk(range_flag == 0, "R8 blanked", int'(range_flag), 0);
    wref(4 * WIN);
    chk(range_flag == 1, "R8 after blanking", int'(range_flag), 1);

    // R7: nominal main clock drives sys_clk
    main_half = 2.5;
    wref(2 * WIN);
    pulse_clear();
    wref(4 * WIN);
    chk(sel_backup == 0, "R7 select main", int'(sel_backup), 0);
    sys_rate("R7 main edges", 5.0);

    // R3 R5 R6: stop the main clock
    main_run = 0;
    wref(3 * WIN);
    chk(loss_flag == 1 && sel_backup == 1, "R3 loss", int'(loss_flag), 1);
    chk(meas_count == 0, "R3 meas zero", int'(meas_count), 0);
    chk(irq == 1, "R9 irq on loss", int'(irq), 1);
    sys_rate("R6 backup edges", 25.0);
    pulse_clear();
    wref(3 * WIN);
    chk(loss_flag == 1, "R5 reasserted while dead", int'(loss_flag), 1);
    chk(range_flag == 0, "R4 dead windows not range", int'(range_flag), 0);
    sys_rate("R6 backup edges after clear", 25.0);

    // R5 R7: restart and return
    main_run = 1;
    wref(2 * WIN);
    pulse_clear();
    wref(4 * WIN);
    chk(loss_flag == 0 && sel_backup == 0, "R5 cleared", int'(sel_backup), 0);
    chk(range_flag == 0, "R4 nominal after return", int'(range_flag), 0);
    sys_rate("R7 main edges after return", 5.0);

    finish_run();
  end
endmodule